// File: doc/BRIEF.md
# Serial Bypass Data Port

This block moves a stream of single data bits, each paired with its own validity flag, between a radio core and a host microcontroller. It does not pass through the radio's serializer/deserializer. The port owns a bit clock that it drives to the host on the shared interrupt line. The bit clock idles high, and every bit period opens with a falling edge. It runs only while a word is in flight. Its rate comes from a programmable divider of the system clock.

The direction input selects one of two modes. In to-host mode the core hands over a parallel word and a valid mask. The port then presents one bit per period on a data line and a valid line, least significant bit first. The lines change at each falling edge, and the host samples them on the following rising edge. In from-host mode the port samples the host's data and valid lines at each falling edge. Once a full word has been collected, it gives the core the word and its mask with a one-cycle strobe. If the direction changes while a word is in flight, that word is dropped and the port returns to idle.

Top module: `sbp_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `bclk_o` is 1, `busy_o` is 0, `hdat_o` and `hval_o` are 0, and `in_stb_o` is 0.
- R2: When `start_i` is accepted with `dir_i`=0 (to-host), bit i of `out_word_i` appears on `hdat_o` and bit i of `out_mask_i` appears on `hval_o`, with i running from 0 upward. Each bit is set in the cycle that `bclk_o` falls and held through the following rising edge.
- R3: When `busy_o` is 0, `hdat_o` and `hval_o` are 0. This includes the cycle straight after the last bit period of a to-host word.
- R4: With `dir_i`=1 (from-host), the port samples `hdat_i` and `hval_i` at each falling edge of `bclk_o`, least significant bit first.
- R5: After WORD_W from-host bits, `in_word_o` bit i equals sampled data AND sampled valid for bit i, so invalid bits read 0. `in_mask_o` bit i equals the sampled valid for bit i. `in_stb_o` is 1 for exactly one cycle, the cycle after `busy_o` falls.
- R6: `bclk_o` stays low for H system clocks and then high for H. H is `half_period_i` latched when the word is accepted, and a value of 0 counts as 1. Between words `bclk_o` is high.
- R7: A word produces exactly WORD_W falling edges of `bclk_o`, and `busy_o` stays 1 for exactly 2·H·WORD_W cycles.
- R8: If `dir_i` changes while `busy_o` is 1, the next cycle shows `busy_o`=0 and `bclk_o`=1, and no strobe follows. The next word starts again from bit 0.
- R9: `start_i` and changes of `half_period_i` or `out_word_i` while `busy_o` is 1 have no effect on the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | 0 = to-host, 1 = from-host |
| half_period_i | input | DIV_W | Bit-clock half period in system clocks (0 acts as 1) |
| start_i | input | 1 | Request to start one word; accepted only when idle |
| out_word_i | input | WORD_W | Word to send to the host |
| out_mask_i | input | WORD_W | Valid flags of the word to send |
| busy_o | output | 1 | A word is in flight |
| in_word_o | output | WORD_W | Word collected from the host |
| in_mask_o | output | WORD_W | Valid flags of the collected word |
| in_stb_o | output | 1 | One-cycle strobe: collected word ready |
| bclk_o | output | 1 | Bit clock on the shared interrupt line |
| hdat_o | output | 1 | Data line toward the host |
| hval_o | output | 1 | Valid line toward the host |
| hdat_i | input | 1 | Data line from the host |
| hval_i | input | 1 | Valid line from the host |

## Verification
A direction change and a new start request can reach the port in the same cycle as work on a word already in flight. To test this, the bench pulses `start_i` and alters `half_period_i` and `out_word_i` in the middle of a to-host word. The word must arrive unchanged and the busy time must follow the half period latched at the start. In a separate run the bench flips `dir_i` partway through a from-host word. The port must be idle and high on `bclk_o` by the next cycle, must give no strobe, and the word that follows must be collected whole.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic {
    DIR_TO_HOST   = 1'b0,
    DIR_FROM_HOST = 1'b1
  } dir_e;
endpackage

// File: rtl/sbp_clkgen.sv
// Bit-clock generator and bit counter. Idles high; each bit period is a
// low half followed by a high half, each half_q system clocks long.
module sbp_clkgen #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             bclk_o,
  output logic             busy_o,
  output logic             launch_o,
  output logic             step_o,
  output logic             done_o
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             busy_q, bclk_q;
  logic [DIV_W-1:0] cnt_q, half_q, half_eff;
  logic [IDX_W-1:0] idx_q;
  logic             tick, rise, step, done, launch;

  always_comb begin
    half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
    launch   = start_i & ~busy_q;
    tick     = busy_q & ~abort_i & (cnt_q == half_q - DIV_W'(1));
    rise     = tick & ~bclk_q;
    step     = tick & bclk_q & (idx_q != LAST_IDX);
    done     = tick & bclk_q & (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bclk_q <= 1'b1;
      cnt_q  <= '0;
      half_q <= DIV_W'(1);
      idx_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      bclk_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      bclk_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= half_eff;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (rise) bclk_q <= 1'b1;
        if (step) begin
          bclk_q <= 1'b0;
          idx_q  <= idx_q + IDX_W'(1);
        end
        if (done) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign bclk_o   = bclk_q;
  assign busy_o   = busy_q;
  assign launch_o = launch;
  assign step_o   = step;
  assign done_o   = done;
endmodule

// File: rtl/sbp_serializer.sv
// To-host path: presents one data/valid pair per bit period, LSB first.
module sbp_serializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic              dat_o,
  output logic              val_o
);
  logic [WORD_W-1:0] dsh_q, vsh_q;
  logic              dat_q, val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsh_q <= '0;
      vsh_q <= '0;
      dat_q <= 1'b0;
      val_q <= 1'b0;
    end else if (clear_i) begin
      dat_q <= 1'b0;
      val_q <= 1'b0;
    end else if (load_i) begin
      dat_q <= word_i[0];
      val_q <= mask_i[0];
      dsh_q <= word_i >> 1;
      vsh_q <= mask_i >> 1;
    end else if (step_i) begin
      dat_q <= dsh_q[0];
      val_q <= vsh_q[0];
      dsh_q <= dsh_q >> 1;
      vsh_q <= vsh_q >> 1;
    end
  end

  assign dat_o = dat_q;
  assign val_o = val_q;
endmodule

// File: rtl/sbp_deserializer.sv
// From-host path: collects data/valid pairs LSB first; an invalid bit
// enters the word as 0.
module sbp_deserializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              dat_i,
  input  logic              val_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              stb_o
);
  logic [WORD_W-1:0] dsh_q, vsh_q, word_q, mask_q;
  logic              stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsh_q  <= '0;
      vsh_q  <= '0;
      word_q <= '0;
      mask_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (sample_i) begin
        dsh_q <= {dat_i & val_i, dsh_q[WORD_W-1:1]};
        vsh_q <= {val_i, vsh_q[WORD_W-1:1]};
      end
      if (finish_i) begin
        word_q <= dsh_q;
        mask_q <= vsh_q;
        stb_q  <= 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign mask_o = mask_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/sbp_port.sv
module sbp_port #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_i,
  input  logic [DIV_W-1:0]  half_period_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] out_word_i,
  input  logic [WORD_W-1:0] out_mask_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] in_word_o,
  output logic [WORD_W-1:0] in_mask_o,
  output logic              in_stb_o,
  output logic              bclk_o,
  output logic              hdat_o,
  output logic              hval_o,
  input  logic              hdat_i,
  input  logic              hval_i
);
  import sbp_pkg::*;

  dir_e run_dir_q;
  logic busy, launch, step, done, abort;
  logic to_host_now, to_host_run;

  assign abort       = busy & (dir_e'(dir_i) != run_dir_q);
  assign to_host_now = (dir_e'(dir_i) == DIR_TO_HOST);
  assign to_host_run = (run_dir_q == DIR_TO_HOST);

  always_ff @(posedge clk) begin
    if (rst)         run_dir_q <= DIR_TO_HOST;
    else if (launch) run_dir_q <= dir_e'(dir_i);
  end

  sbp_clkgen #(.WORD_W(WORD_W), .DIV_W(DIV_W)) clkgen_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .abort_i  (abort),
    .half_i   (half_period_i),
    .bclk_o   (bclk_o),
    .busy_o   (busy),
    .launch_o (launch),
    .step_o   (step),
    .done_o   (done)
  );

  sbp_serializer #(.WORD_W(WORD_W)) ser_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (launch & to_host_now),
    .step_i  (step & to_host_run),
    .clear_i (done | abort),
    .word_i  (out_word_i),
    .mask_i  (out_mask_i),
    .dat_o   (hdat_o),
    .val_o   (hval_o)
  );

  sbp_deserializer #(.WORD_W(WORD_W)) des_i (
    .clk      (clk),
    .rst      (rst),
    .sample_i ((launch & ~to_host_now) | (step & ~to_host_run)),
    .finish_i (done & ~to_host_run),
    .dat_i    (hdat_i),
    .val_i    (hval_i),
    .word_o   (in_word_o),
    .mask_o   (in_mask_o),
    .stb_o    (in_stb_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sbp_port_chk.sv
module sbp_port_chk (
  input logic clk,
  input logic rst,
  input logic dir_i,
  input logic busy_o,
  input logic bclk_o,
  input logic hdat_o,
  input logic hval_o,
  input logic in_stb_o
);
  // R6: bit clock rests high between words
  a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> bclk_o);

  // R3: lines toward the host are quiet when idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!hval_o && !hdat_o));

  // R2: lines only move with a falling edge, so they hold while the clock is high
  a_r2_hold_high: assert property (@(posedge clk) disable iff (rst)
    (busy_o && bclk_o) |-> ($stable(hval_o) && $stable(hdat_o)));

  // R5: strobe lasts one cycle
  a_r5_stb_pulse: assert property (@(posedge clk) disable iff (rst)
    in_stb_o |=> !in_stb_o);

  // R5: strobe follows the end of a word
  a_r5_stb_after_word: assert property (@(posedge clk) disable iff (rst)
    in_stb_o |-> (!busy_o && $past(busy_o)));

  // R8: direction change while busy drops the word
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (dir_i != $past(dir_i))) |=> (!busy_o && bclk_o && !in_stb_o));
endmodule

bind sbp_port sbp_port_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .dir_i    (dir_i),
  .busy_o   (busy_o),
  .bclk_o   (bclk_o),
  .hdat_o   (hdat_o),
  .hval_o   (hval_o),
  .in_stb_o (in_stb_o)
);

// File: tb/sbp_port_tb_top.sv
module sbp_port_tb_top;
  localparam int W  = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          dir_i = 1'b0;
  logic [DW-1:0] half_period_i = DW'(1);
  logic          start_i = 1'b0;
  logic [W-1:0]  out_word_i = '0, out_mask_i = '0;
  logic          busy_o, in_stb_o, bclk_o, hdat_o, hval_o;
  logic [W-1:0]  in_word_o, in_mask_o;
  logic          hdat_i = 1'b0, hval_i = 1'b0;

  sbp_port #(.WORD_W(W), .DIV_W(DW)) dut_i (
    .clk(clk), .rst(rst), .dir_i(dir_i), .half_period_i(half_period_i),
    .start_i(start_i), .out_word_i(out_word_i), .out_mask_i(out_mask_i),
    .busy_o(busy_o), .in_word_o(in_word_o), .in_mask_o(in_mask_o),
    .in_stb_o(in_stb_o), .bclk_o(bclk_o), .hdat_o(hdat_o), .hval_o(hval_o),
    .hdat_i(hdat_i), .hval_i(hval_i)
  );

  int total = 0;
  int bad   = 0;

  logic [W-1:0] q_out_w[$], q_out_m[$], q_in_w[$], q_in_m[$];
  logic [W-1:0] rw, rm, txw, txm;
  int  kk = 0, k = 0, falls = 0, stb_seen = 0;
  bit  mon_en = 0, drv_en = 0, prev_clk = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Host model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bclk_o && !prev_clk) begin
        if (mon_en && kk < W) begin
          rw[kk] = hdat_o;
          rm[kk] = hval_o;
          kk++;
          if (kk == W) begin
            if (q_out_w.size() == 0) chk(0, "R2", "unexpected to-host word", {16'h0, rw}, 0);
            else begin
              logic [W-1:0] ew, em;
              ew = q_out_w.pop_front();
              em = q_out_m.pop_front();
              chk(rw == ew, "R2", "to-host data", {16'h0, rw}, {16'h0, ew});
              chk(rm == em, "R2", "to-host valid", {16'h0, rm}, {16'h0, em});
            end
          end
        end
        if (drv_en) begin
          k++;
          if (k < W) begin hdat_i = txw[k]; hval_i = txm[k]; end
          else       begin hdat_i = 1'b0;   hval_i = 1'b0;   end
        end
      end
      if (!bclk_o && prev_clk) falls++;
      if (in_stb_o) begin
        stb_seen++;
        if (q_in_w.size() == 0) chk(0, "R5", "unexpected strobe", {16'h0, in_word_o}, 0);
        else begin
          logic [W-1:0] ew, em;
          ew = q_in_w.pop_front();
          em = q_in_m.pop_front();
          chk(in_word_o == ew, "R4", "from-host word", {16'h0, in_word_o}, {16'h0, ew});
          chk(in_mask_o == em, "R5", "from-host mask", {16'h0, in_mask_o}, {16'h0, em});
        end
      end
      prev_clk = bclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] w, input logic [W-1:0] m,
                      input int h, input bit poke);
    int heff, n;
    heff = (h == 0) ? 1 : h;
    dir_i = 1'b0; out_word_i = w; out_mask_i = m; half_period_i = DW'(h);
    kk = 0; falls = 0; mon_en = 1;
    q_out_w.push_back(w); q_out_m.push_back(m);
    pulse_start();
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      if (n == heff)     chk(bclk_o == 1'b0, "R6", "low half", {31'h0, bclk_o}, 0);
      if (n == heff + 1) chk(bclk_o == 1'b1, "R6", "high half", {31'h0, bclk_o}, 1);
      if (poke && n == 3 * heff) begin
        start_i = 1'b1; out_word_i = ~w; half_period_i = DW'(h + 3); // R9
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(n == 2 * heff * W, poke ? "R9" : "R7", "busy cycles", n, 2 * heff * W);
    chk(falls == W, "R7", "falling edges", falls, W);
    chk(!hval_o && !hdat_o, "R3", "lines after word", {30'h0, hdat_o, hval_o}, 0);
    chk(q_out_w.size() == 0, "R2", "word delivered", q_out_w.size(), 0);
    mon_en = 0;
  endtask

  task automatic recv(input logic [W-1:0] w, input logic [W-1:0] m, input int h);
    int s0, n;
    dir_i = 1'b1; half_period_i = DW'(h);
    txw = w; txm = m; k = 0; hdat_i = w[0]; hval_i = m[0]; drv_en = 1;
    q_in_w.push_back(w & m); q_in_m.push_back(m);
    s0 = stb_seen;
    pulse_start();
    n = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk); end
    @(negedge clk); @(negedge clk);
    drv_en = 0;
    chk(stb_seen == s0 + 1, "R5", "strobe cycles", stb_seen - s0, 1);
    chk(!in_stb_o, "R5", "strobe low after", {31'h0, in_stb_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bclk_o && !busy_o && !hdat_o && !hval_o && !in_stb_o, "R1", "reset state",
        {27'h0, bclk_o, busy_o, hdat_o, hval_o, in_stb_o}, 32'h10);
    rst = 1'b0;
    @(negedge clk);
    chk(bclk_o && !busy_o && !hval_o && !in_stb_o, "R1", "after reset",
        {28'h0, bclk_o, busy_o, hval_o, in_stb_o}, 32'h8);

    send(16'hA5C3, 16'hFFFF, 1, 0);
    send(16'h1234, 16'h0F0F, 2, 0);
    send(16'hFFFF, 16'h8001, 3, 0);
    send(16'h5A5A, 16'hFFFF, 0, 0);
    send(16'hC001, 16'h7FFE, 2, 1);

    recv(16'hBEEF, 16'hFFFF, 1);
    recv(16'h1357, 16'hF0F0, 2);
    recv(16'hFFFF, 16'h0000, 1);
    recv(16'h0001, 16'h8001, 3);

    // R8: abort by direction change mid-word
    begin
      int s0;
      dir_i = 1'b1; half_period_i = DW'(2);
      txw = 16'h00FF; txm = 16'hFFFF; k = 0; hdat_i = 1'b1; hval_i = 1'b1; drv_en = 1;
      s0 = stb_seen;
      pulse_start();
      repeat (9) @(negedge clk);
      dir_i = 1'b0;
      @(negedge clk);
      chk(!busy_o && bclk_o, "R8", "abort to idle", {30'h0, busy_o, bclk_o}, 1);
      repeat (10) @(negedge clk);
      chk(stb_seen == s0, "R8", "no strobe on abort", stb_seen - s0, 0);
      drv_en = 0;
    end
    recv(16'h2468, 16'hFFFF, 2);  // R8: fresh word from bit 0 after abort

    chk(q_in_w.size() == 0, "R5", "from-host queue drained", q_in_w.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule